// File: doc/BRIEF.md
# Checkpointed Speculative Register Map

This block holds the frontend view of the register state: one entry per architectural register, each holding the newest speculative value or tag for that register. Rename writes update this live map. Each decoded branch takes a full copy of the live map into one of a small set of checkpoint slots, and the decoder receives the slot number. While the branch is unresolved, a writeback from any instruction older than that branch is also written into the branch's copy, so the copy always holds the state the frontend should see right after the branch.

When a branch turns out mispredicted, its slot number is presented and the live map is replaced by that slot's contents in a single cycle. This can happen before the branch is the oldest instruction. That slot and every slot allocated after it are released. A branch that commits as correctly predicted releases the oldest slot. Slots are taken and released in circular order, and decode stalls while every slot is in use. Ages are compared with wrap-aware sequence numbers. The checkpoint count must be a power of two.

Top module: `ckpt_rat`

## Requirements
- R1: After reset, live entry i reads back the value i, no slot is held, `br_id` is 0 and `br_ready` is 1.
- R2: A rename with `ren_valid` high and `ren_ready` high replaces the addressed live entry from the next cycle on; `rd_data` shows live entry `rd_arch` combinationally.
- R3: Slots are handed out in circular order 0,1,2,3,0,...; `br_id` names the slot the next branch gets, `br_ready` is low while all 4 slots are held, and a branch presented while `br_ready` is low changes nothing.
- R4: A new checkpoint captures the live map including a writeback in the same cycle, but excluding a rename in the same cycle.
- R5: A writeback updates the live entry and the same entry in every held checkpoint whose branch is younger than the writeback; checkpoints of older branches keep their value.
- R6: A mispredict with `mis_id` loads the whole live map from that slot (including a same-cycle writeback into it), visible on the next cycle.
- R7: A mispredict releases slot `mis_id` and all slots allocated after it, so the next cycle `br_id` equals `mis_id`.
- R8: While `mis_valid` is high, `ren_ready` and `br_ready` are low and a presented rename or branch has no effect.
- R9: `cmt_valid` releases the oldest held slot; with no slot held it is ignored.
- R10: Sequence a is younger than b when (a - b) modulo 2^SEQ_W is nonzero and below 2^(SEQ_W-1), so ages stay correct across the sequence wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename write request |
| ren_arch | input | AW | Renamed architectural register |
| ren_data | input | DATA_W | New map value for that register |
| ren_ready | output | 1 | Rename accepted this cycle |
| br_valid | input | 1 | Branch decoded, take a checkpoint |
| br_seq | input | SEQ_W | Sequence number of the branch |
| br_ready | output | 1 | A slot is free to take a checkpoint |
| br_id | output | CW | Slot the next branch receives |
| wb_valid | input | 1 | Writeback of a register value |
| wb_seq | input | SEQ_W | Sequence number of the writing instruction |
| wb_arch | input | AW | Register written back |
| wb_data | input | DATA_W | Value written back |
| mis_valid | input | 1 | Branch misprediction resolved |
| mis_id | input | CW | Slot of the mispredicted branch (must be held) |
| cmt_valid | input | 1 | Oldest branch committed as correct |
| rd_arch | input | AW | Live map read address |
| rd_data | output | DATA_W | Live map read data |

## Verification
The bench drives a long random mix of renames, branches, writebacks at varied ages, commits and mispredicts against a model built from the requirements, and reads the live map at random addresses every cycle. A directed run places two branches on either side of the sequence wrap with a writeback whose age falls between them, then restores each slot in turn, which separates a correct age compare from one that ignores the wrap or updates every slot. Other directed steps put a rename and a writeback in the same cycle as a snapshot or a restore, which tells apart the ordering of capture, update and restore, and fill all slots to show the stall and release order.

// File: rtl/ckpt_rat.sv
module ckpt_rat #(
  parameter int NUM_ARCH = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_CKPT = 4,
  parameter int SEQ_W    = 6,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int CW = $clog2(NUM_CKPT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_valid,
  input  logic [AW-1:0]     ren_arch,
  input  logic [DATA_W-1:0] ren_data,
  output logic              ren_ready,
  input  logic              br_valid,
  input  logic [SEQ_W-1:0]  br_seq,
  output logic              br_ready,
  output logic [CW-1:0]     br_id,
  input  logic              wb_valid,
  input  logic [SEQ_W-1:0]  wb_seq,
  input  logic [AW-1:0]     wb_arch,
  input  logic [DATA_W-1:0] wb_data,
  input  logic              mis_valid,
  input  logic [CW-1:0]     mis_id,
  input  logic              cmt_valid,
  input  logic [AW-1:0]     rd_arch,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0]   live_q  [NUM_ARCH];
  logic [DATA_W-1:0]   live_wb [NUM_ARCH];
  logic [DATA_W-1:0]   live_nx [NUM_ARCH];
  logic [DATA_W-1:0]   ck_q    [NUM_CKPT][NUM_ARCH];
  logic [DATA_W-1:0]   ck_nx   [NUM_CKPT][NUM_ARCH];
  logic [SEQ_W-1:0]    seq_q   [NUM_CKPT];
  logic [CW-1:0]       head_q;
  logic [CW:0]         cnt_q;
  logic [CW-1:0]       tail;
  logic [NUM_CKPT-1:0] held;
  logic                take, pop;

  function automatic logic is_younger(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[SEQ_W-1];
  endfunction

  assign tail      = head_q + cnt_q[CW-1:0];
  assign ren_ready = !mis_valid;
  assign br_ready  = (cnt_q != (CW+1)'(NUM_CKPT)) && !mis_valid;
  assign br_id     = tail;
  assign take      = br_valid && br_ready;
  assign pop       = cmt_valid && (cnt_q != '0);
  assign rd_data   = live_q[rd_arch];

  for (genvar i = 0; i < NUM_CKPT; i++) begin : g_held
    logic [CW-1:0] off;
    assign off     = CW'(i) - head_q;
    assign held[i] = {1'b0, off} < cnt_q;
  end

  always_comb begin
    for (int a = 0; a < NUM_ARCH; a++) begin
      live_wb[a] = (wb_valid && wb_arch == AW'(a)) ? wb_data : live_q[a];
      for (int i = 0; i < NUM_CKPT; i++)
        ck_nx[i][a] = (wb_valid && wb_arch == AW'(a) && held[i] && is_younger(seq_q[i], wb_seq))
                      ? wb_data : ck_q[i][a];
    end
    for (int a = 0; a < NUM_ARCH; a++)
      live_nx[a] = mis_valid ? ck_nx[mis_id][a]
                 : (ren_valid && ren_arch == AW'(a)) ? ren_data : live_wb[a];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
      for (int a = 0; a < NUM_ARCH; a++) live_q[a] <= DATA_W'(a);
      for (int i = 0; i < NUM_CKPT; i++) begin
        seq_q[i] <= '0;
        for (int a = 0; a < NUM_ARCH; a++) ck_q[i][a] <= '0;
      end
    end else begin
      head_q <= head_q + CW'(pop);
      if (mis_valid) cnt_q <= {1'b0, mis_id - head_q} - (CW+1)'(pop);
      else           cnt_q <= cnt_q + (CW+1)'(take) - (CW+1)'(pop);
      live_q <= live_nx;
      for (int i = 0; i < NUM_CKPT; i++) begin
        if (take && tail == CW'(i)) begin
          ck_q[i]  <= live_wb;
          seq_q[i] <= br_seq;
        end else begin
          ck_q[i] <= ck_nx[i];
        end
      end
    end
  end
endmodule

// File: rtl/ckpt_rat_chk.sv
module ckpt_rat_chk #(
  parameter int NUM_ARCH = 8,
  parameter int DATA_W   = 8,
  parameter int NUM_CKPT = 4,
  localparam int AW = $clog2(NUM_ARCH),
  localparam int CW = $clog2(NUM_CKPT)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ren_valid,
  input logic [AW-1:0]     ren_arch,
  input logic [DATA_W-1:0] ren_data,
  input logic              ren_ready,
  input logic              br_valid,
  input logic              br_ready,
  input logic [CW-1:0]     br_id,
  input logic              wb_valid,
  input logic              mis_valid,
  input logic [CW-1:0]     mis_id,
  input logic [AW-1:0]     rd_arch,
  input logic [DATA_W-1:0] rd_data,
  input logic [CW:0]       cnt_q
);
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= (CW+1)'(NUM_CKPT));

  assert_alloc_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (br_valid && br_ready) |=> br_id == CW'($past(br_id) + 1'b1));

  assert_alloc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!br_valid && !mis_valid) |=> $stable(br_id));

  assert_restore_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mis_valid |=> br_id == $past(mis_id));

  assert_rename_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_ready && !wb_valid) |=>
      (rd_arch != $past(ren_arch)) || (rd_data == $past(ren_data)));

  assert_map_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren_valid && !wb_valid && !mis_valid) |=>
      (rd_arch != $past(rd_arch)) || $stable(rd_data));
endmodule

bind ckpt_rat ckpt_rat_chk #(.NUM_ARCH(NUM_ARCH), .DATA_W(DATA_W), .NUM_CKPT(NUM_CKPT)) u_chk (
  .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_data(ren_data),
  .ren_ready(ren_ready), .br_valid(br_valid), .br_ready(br_ready), .br_id(br_id),
  .wb_valid(wb_valid), .mis_valid(mis_valid), .mis_id(mis_id), .rd_arch(rd_arch),
  .rd_data(rd_data), .cnt_q(cnt_q)
);

// File: tb/tb_ckpt_rat.sv
`timescale 1ns/10ps
module tb_ckpt_rat;
  logic clk = 1'b0, rst_n = 1'b0;
  logic       ren_valid = 0, br_valid = 0, wb_valid = 0, mis_valid = 0, cmt_valid = 0;
  logic [2:0] ren_arch = 0, wb_arch = 0, rd_arch = 0;
  logic [7:0] ren_data = 0, wb_data = 0;
  logic [5:0] br_seq = 0, wb_seq = 0;
  logic [1:0] mis_id = 0;
  logic       ren_ready, br_ready;
  logic [1:0] br_id;
  logic [7:0] rd_data;

  always #2.5 clk = ~clk;

  ckpt_rat dut (
    .clk(clk), .rst_n(rst_n),
    .ren_valid(ren_valid), .ren_arch(ren_arch), .ren_data(ren_data), .ren_ready(ren_ready),
    .br_valid(br_valid), .br_seq(br_seq), .br_ready(br_ready), .br_id(br_id),
    .wb_valid(wb_valid), .wb_seq(wb_seq), .wb_arch(wb_arch), .wb_data(wb_data),
    .mis_valid(mis_valid), .mis_id(mis_id), .cmt_valid(cmt_valid),
    .rd_arch(rd_arch), .rd_data(rd_data)
  );

  int errs = 0, checks = 0;
  bit done = 0;
  logic [7:0] m_live [8];
  logic [7:0] m_ck   [4][8];
  logic [5:0] m_seq  [4];
  logic [1:0] m_head = 0;
  int         m_cnt  = 0;

  function automatic bit younger(logic [5:0] a, logic [5:0] b);
    logic [5:0] d;
    d = a - b;
    return d != 0 && !d[5];
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic readback(string tag);
    for (int a = 0; a < 8; a++) begin
      rd_arch = 3'(a);
      #0.1;
      chk(tag, rd_data, m_live[a]);
    end
  endtask

  task automatic step(bit rv, logic [2:0] ra, logic [7:0] rdv, bit bv, logic [5:0] bs,
                      bit wv, logic [5:0] ws, logic [2:0] wa, logic [7:0] wd,
                      bit mv, logic [1:0] mi, bit cv, string tag);
    logic [1:0] tl;
    logic [7:0] lw [8];
    bit take, pop;
    ren_valid = rv; ren_arch = ra; ren_data = rdv;
    br_valid = bv; br_seq = bs;
    wb_valid = wv; wb_seq = ws; wb_arch = wa; wb_data = wd;
    mis_valid = mv; mis_id = mi; cmt_valid = cv;
    rd_arch = 3'($urandom % 8);
    #0.5;
    tl = m_head + 2'(m_cnt);
    chk({tag, " br_ready R3"}, br_ready, (m_cnt != 4) && !mv);
    chk({tag, " br_id R3"}, br_id, tl);
    chk({tag, " ren_ready R8"}, ren_ready, !mv);
    chk({tag, " rd_data R2"}, rd_data, m_live[rd_arch]);
    take = bv && (m_cnt != 4) && !mv;
    pop  = cv && (m_cnt != 0);
    // R5 R10: writeback reaches held checkpoints of younger branches only
    for (int i = 0; i < 4; i++)
      if (wv && int'(2'(2'(i) - m_head)) < m_cnt && younger(m_seq[i], ws)) m_ck[i][wa] = wd;
    lw = m_live;
    if (wv) lw[wa] = wd;
    // R4: snapshot includes writeback, excludes rename
    if (take) begin m_ck[tl] = lw; m_seq[tl] = bs; end
    if (mv) m_live = m_ck[mi];
    else begin
      m_live = lw;
      if (rv) m_live[ra] = rdv;
    end
    if (mv) m_cnt = int'(2'(mi - m_head)) - int'(pop);
    else    m_cnt = m_cnt + int'(take) - int'(pop);
    m_head = m_head + 2'(pop);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic run_random();
    logic [5:0] nseq = 6'd20;
    for (int n = 0; n < 4000; n++) begin
      bit mv, bv, wv, cv, rv;
      logic [1:0] mi;
      mv = (m_cnt > 0) && ($urandom % 8 == 0);
      mi = mv ? m_head + 2'($urandom % m_cnt) : 2'd0;
      bv = ($urandom % 3 == 0);
      wv = ($urandom % 2 == 0);
      rv = ($urandom % 2 == 0);
      cv = !mv && ($urandom % 5 == 0);
      step(rv, 3'($urandom), 8'($urandom), bv, nseq, wv, nseq - 6'($urandom % 10),
           3'($urandom), 8'($urandom), mv, mi, cv, "random R4 R5 R6 R9 R10");
      if (bv) nseq = nseq + 6'(1 + $urandom % 3);
      if (n % 97 == 0) readback("random map R2 R6");
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #900000;
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int a = 0; a < 8; a++) m_live[a] = 8'(a);
    for (int i = 0; i < 4; i++) begin
      m_seq[i] = 0;
      for (int a = 0; a < 8; a++) m_ck[i][a] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("reset br_id R1", br_id, 0);
    chk("reset br_ready R1", br_ready, 1);
    readback("reset map R1");

    // R4 R5 R6 R10: branches straddling the sequence wrap
    step(1, 3'd1, 8'hA1, 0, 0, 0, 0, 0, 0, 0, 0, 0, "setup R2");
    step(1, 3'd2, 8'hB2, 1, 6'd62, 1, 6'd60, 3'd3, 8'hC3, 0, 0, 0, "snap R4");
    step(0, 0, 0, 1, 6'd1, 0, 0, 0, 0, 0, 0, 0, "snap wrap R10");
    step(0, 0, 0, 0, 0, 1, 6'd63, 3'd4, 8'hD4, 0, 0, 0, "wb between R5 R10");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd1, 0, "restore R6");
    readback("restore slot1 R6 R5");
    step(1, 3'd5, 8'hE5, 1, 6'd2, 0, 0, 0, 0, 1, 2'd0, 0, "restore blocked R8");
    readback("restore slot0 R4 R5 R8 R10");
    // R7 checked by br_id in next step; R9 commit with nothing held
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "free all R7");
    idle("empty commit R9");

    // R3 fill, stall, R9 release oldest
    for (int k = 0; k < 4; k++)
      step(0, 0, 0, 1, 6'(10 + k), 0, 0, 0, 0, 0, 0, 0, "fill R3");
    step(0, 0, 0, 1, 6'd14, 0, 0, 0, 0, 0, 0, 0, "full ignored R3");
    idle("full hold R3");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "commit R9");
    idle("after commit R9");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd2, 0, "partial restore R7");
    idle("after partial R7");

    run_random();
    readback("final map R2");
    done = 1;
    finish_run();
  end
endmodule